// File: doc/BRIEF.md
# Indexed Mixed-Sign Byte Dot-Product Accumulator

This block is a vector datapath that updates a wide accumulator with byte dot products. Each 32-bit lane of the first operand carries four unsigned bytes. The second operand supplies four signed bytes, but it is not read lane by lane. A 2-bit index picks one 32-bit group in every 128-bit segment, and all four lanes of that segment use the group. Each lane adds the four byte products to its own accumulator lane. The result wraps at 32 bits.

The vector width is a parameter and must be a whole number of 128-bit segments. Any other width stops elaboration. There is one register stage, and a small two-state controller tracks whether that stage holds a result.

The controller has two states. ST_EMPTY means no result is held, and ST_FULL means a result is presented. It has four transitions:

| Transition | From | To | Condition |
|---|---|---|---|
| load | ST_EMPTY | ST_FULL | `in_valid` is high |
| reload | ST_FULL | ST_FULL | `in_valid` is high |
| drain | ST_FULL | ST_EMPTY | `in_valid` is low |
| idle | ST_EMPTY | ST_EMPTY | `in_valid` is low |

Synchronous reset forces ST_EMPTY.

Top module: `mixdot_acc`

## Requirements
- R1: Byte i of lane e of `op_u` is bits [32e+8i+7 : 32e+8i], and lane 0 is at bit 0. Each such byte is read as an unsigned value from 0 to 255.
- R2: Bytes taken from `op_s` are read as two's-complement values from -128 to 127.
- R3: Lane e takes its signed bytes from the 32-bit group of `op_s` at lane position 4*floor(e/4) + `idx`. The groups of `op_s` that are not selected have no effect on `acc_out`.
- R4: Each result lane equals the `acc_in` lane plus the sum, over i = 0 to 3, of byte i of the `op_u` lane times byte i of the selected group. The addition wraps modulo 2^32 and does not saturate.
- R5: Every lane of `acc_out` is updated on every accepted input. There is no per-lane mask.
- R6: `out_valid` is high in the cycle after a clock edge that samples `in_valid` high. It is low in the cycle after an edge that samples `in_valid` low.
- R7: A clock edge with `rst` high sets `out_valid` to 0 and `acc_out` to all zeros.
- R8: While `in_valid` is low, `acc_out` keeps its value, whatever is on the operand inputs.
- R9: An input with `op_u` equal to all zeros produces an `acc_out` equal to that input's `acc_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks the operands as a transaction to accept |
| idx | input | 2 | Selects the 32-bit group within each 128-bit segment of `op_s` |
| op_u | input | VEC_W | Unsigned byte operand, one group of four bytes per lane |
| op_s | input | VEC_W | Signed byte operand; only the indexed group of each segment is used |
| acc_in | input | VEC_W | Accumulator lanes to add to |
| out_valid | output | 1 | High while `acc_out` holds a new result |
| acc_out | output | VEC_W | Updated accumulator lanes |

## Verification
The bench builds the block with VEC_W = 384, which gives three segments and twelve lanes. At that width, one index value selects a different group in each segment, and the results show whether a lane draws from its own segment or from another. The reference model runs every index value with random operands. It also covers the extreme product of 0xFF and 0x80 bytes and accumulators just below both 32-bit wrap points. Separate tests check that the unselected groups are ignored and that back-to-back transactions produce the correct latency.

// File: rtl/mixdot_pkg.sv
package mixdot_pkg;
    localparam int SEG_W         = 128;
    localparam int LANE_W        = 32;
    localparam int BYTE_W        = 8;
    localparam int LANES_PER_SEG = SEG_W / LANE_W;
    localparam int BYTES_PER_LN  = LANE_W / BYTE_W;
    localparam int IDX_W         = $clog2(LANES_PER_SEG);
    localparam int PROD_W        = 2 * BYTE_W + 1;
    localparam int DOT_W         = PROD_W + $clog2(BYTES_PER_LN);

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_state_t;
endpackage

// File: rtl/mixdot_group_sel.sv
module mixdot_group_sel
    import mixdot_pkg::*;
(
    input  logic [SEG_W-1:0]  seg,
    input  logic [IDX_W-1:0]  idx,
    output logic [LANE_W-1:0] grp
);
    always_comb begin
        grp = '0;
        for (int g = 0; g < LANES_PER_SEG; g++) begin
            if (idx == IDX_W'(g)) grp = seg[g*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/mixdot_lane.sv
module mixdot_lane
    import mixdot_pkg::*;
(
    input  logic [LANE_W-1:0] u_word,
    input  logic [LANE_W-1:0] s_word,
    input  logic [LANE_W-1:0] acc_word,
    output logic [LANE_W-1:0] new_word
);
    logic signed [PROD_W-1:0] prod [BYTES_PER_LN];
    logic signed [DOT_W-1:0]  dot;

    for (genvar i = 0; i < BYTES_PER_LN; i++) begin : g_prod
        logic signed [BYTE_W:0]   u_ext;
        logic signed [BYTE_W-1:0] s_byte;
        assign u_ext   = {1'b0, u_word[i*BYTE_W +: BYTE_W]};
        assign s_byte  = s_word[i*BYTE_W +: BYTE_W];
        assign prod[i] = PROD_W'(u_ext * s_byte);
    end

    always_comb begin
        dot = '0;
        for (int i = 0; i < BYTES_PER_LN; i++) begin
            dot = dot + {{(DOT_W-PROD_W){prod[i][PROD_W-1]}}, prod[i]};
        end
    end

    assign new_word = acc_word + {{(LANE_W-DOT_W){dot[DOT_W-1]}}, dot};
endmodule

// File: rtl/mixdot_acc.sv
module mixdot_acc
    import mixdot_pkg::*;
#(
    parameter int VEC_W = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       idx,
    input  logic [VEC_W-1:0] op_u,
    input  logic [VEC_W-1:0] op_s,
    input  logic [VEC_W-1:0] acc_in,
    output logic             out_valid,
    output logic [VEC_W-1:0] acc_out
);
    localparam int NSEG  = VEC_W / SEG_W;
    localparam int NLANE = VEC_W / LANE_W;

    if (VEC_W < SEG_W || (VEC_W % SEG_W) != 0) begin : g_bad_width
        $error("mixdot_acc: VEC_W must be a positive multiple of 128");
    end

    stage_state_t state, state_nxt;
    logic [VEC_W-1:0]  acc_nxt;
    logic [LANE_W-1:0] seg_grp [NSEG];

    for (genvar sg = 0; sg < NSEG; sg++) begin : g_seg
        mixdot_group_sel u_sel (
            .seg (op_s[sg*SEG_W +: SEG_W]),
            .idx (idx),
            .grp (seg_grp[sg])
        );
        for (genvar ln = 0; ln < LANES_PER_SEG; ln++) begin : g_lane
            localparam int E = sg*LANES_PER_SEG + ln;
            mixdot_lane u_lane (
                .u_word   (op_u[E*LANE_W +: LANE_W]),
                .s_word   (seg_grp[sg]),
                .acc_word (acc_in[E*LANE_W +: LANE_W]),
                .new_word (acc_nxt[E*LANE_W +: LANE_W])
            );
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_EMPTY: state_nxt = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_nxt = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_nxt = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_EMPTY;
        else     state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst)           acc_out <= '0;
        else if (in_valid) acc_out <= acc_nxt;
    end

    assign out_valid = (state == ST_FULL);

    if (NLANE < LANES_PER_SEG) begin : g_never
        $error("mixdot_acc: lane count below one segment");
    end
endmodule

// File: rtl/mixdot_chk.sv
module mixdot_chk #(
    parameter int VEC_W = 256
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [VEC_W-1:0] op_u,
    input logic [VEC_W-1:0] acc_in,
    input logic             out_valid,
    input logic [VEC_W-1:0] acc_out
);
    // R6
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R6
    valid_drops_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R7
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && acc_out == '0));
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(acc_out));
    // R9
    zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_u == '0) |=> (acc_out == $past(acc_in)));
endmodule

bind mixdot_acc mixdot_chk #(.VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_u      (op_u),
    .acc_in    (acc_in),
    .out_valid (out_valid),
    .acc_out   (acc_out)
);

// File: tb/test_mixdot_acc.sv
module test_mixdot_acc;
    localparam int CLK_PERIOD = 10;
    localparam int VEC_W = 384;
    localparam int NLANE = VEC_W / 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [1:0]       idx = '0;
    logic [VEC_W-1:0] op_u = '0, op_s = '0, acc_in = '0;
    logic             out_valid;
    logic [VEC_W-1:0] acc_out;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mixdot_acc #(.VEC_W(VEC_W)) i_mixdot_acc (
        .clk(clk), .rst(rst), .in_valid(in_valid), .idx(idx),
        .op_u(op_u), .op_s(op_s), .acc_in(acc_in),
        .out_valid(out_valid), .acc_out(acc_out)
    );

    function automatic logic [VEC_W-1:0] model(input logic [VEC_W-1:0] u,
            input logic [VEC_W-1:0] s, input logic [VEC_W-1:0] a, input logic [1:0] ix);
        logic [VEC_W-1:0] r;
        for (int e = 0; e < NLANE; e++) begin
            int g = (e - (e % 4)) + int'(ix);
            logic [31:0] sum = a[e*32 +: 32];
            for (int i = 0; i < 4; i++) begin
                int ub = int'(u[e*32 + i*8 +: 8]);
                logic signed [7:0] sbv = s[g*32 + i*8 +: 8];
                int sb = int'(sbv);
                sum = sum + 32'(ub * sb);
            end
            r[e*32 +: 32] = sum;
        end
        return r;
    endfunction

    function automatic logic [VEC_W-1:0] rnd_vec();
        logic [VEC_W-1:0] v;
        for (int k = 0; k < NLANE; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic check_vec(input string req, input logic [VEC_W-1:0] act,
                             input logic [VEC_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One transaction; checks result and valid one cycle later.
    task automatic run_op(input string req, input logic [VEC_W-1:0] u,
            input logic [VEC_W-1:0] s, input logic [VEC_W-1:0] a, input logic [1:0] ix);
        @(negedge clk);
        op_u = u; op_s = s; acc_in = a; idx = ix; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_bit({req, " R6 valid"}, out_valid, 1'b1);
        check_vec(req, acc_out, model(u, s, a, ix));
    endtask

    task automatic t_reset();
        check_bit("R7 out_valid after reset", out_valid, 1'b0);
        check_vec("R7 acc_out after reset", acc_out, '0);
    endtask

    task automatic t_random_all_idx();
        for (int ix = 0; ix < 4; ix++)
            for (int n = 0; n < 3; n++)
                run_op("R1 R2 R3 R4 R5 random", rnd_vec(), rnd_vec(), rnd_vec(), 2'(ix));
    endtask

    task automatic t_extremes();
        logic [VEC_W-1:0] ones = '1;
        logic [VEC_W-1:0] m80, p7f, near_max, near_min;
        for (int k = 0; k < VEC_W/8; k++) begin
            m80[k*8 +: 8] = 8'h80;
            p7f[k*8 +: 8] = 8'h7F;
        end
        for (int e = 0; e < NLANE; e++) begin
            near_max[e*32 +: 32] = 32'hFFFF_FFF0 + 32'(e);
            near_min[e*32 +: 32] = 32'h8000_0000 + 32'(e);
        end
        run_op("R2 R4 ff x 80", ones, m80, '0, 2'd1);
        check_vec("R4 ff x 80 lane0 literal", acc_out[31:0], 32'hFFFE_0200);
        run_op("R4 wrap above max", ones, p7f, near_max, 2'd2);
        run_op("R4 wrap below min", ones, m80, near_min, 2'd3);
        run_op("R4 wrap 7fff", ones, p7f, {NLANE{32'h7FFF_FFFF}}, 2'd0);
    endtask

    task automatic t_unselected_ignored();
        logic [VEC_W-1:0] u = rnd_vec(), s = rnd_vec(), a = rnd_vec();
        logic [VEC_W-1:0] first, s2;
        run_op("R3 base", u, s, a, 2'd2);
        first = acc_out;
        s2 = rnd_vec();
        for (int sg = 0; sg < VEC_W/128; sg++)
            s2[sg*128 + 64 +: 32] = s[sg*128 + 64 +: 32];
        run_op("R3 other groups changed", u, s2, a, 2'd2);
        check_vec("R3 unselected groups ignored", acc_out, first);
    endtask

    task automatic t_zero_u();
        logic [VEC_W-1:0] a = rnd_vec();
        run_op("R9 zero op_u", '0, rnd_vec(), a, 2'd1);
        check_vec("R9 passthrough", acc_out, a);
    endtask

    task automatic t_hold();
        logic [VEC_W-1:0] held;
        run_op("R8 setup", rnd_vec(), rnd_vec(), rnd_vec(), 2'd0);
        held = acc_out;
        op_u = rnd_vec(); op_s = rnd_vec(); acc_in = rnd_vec(); idx = 2'd3;
        @(negedge clk);
        check_bit("R6 valid drops", out_valid, 1'b0);
        check_vec("R8 hold while idle", acc_out, held);
        @(negedge clk);
        check_vec("R8 hold second cycle", acc_out, held);
    endtask

    task automatic t_back_to_back();
        logic [VEC_W-1:0] u1 = rnd_vec(), s1 = rnd_vec(), a1 = rnd_vec();
        logic [VEC_W-1:0] u2 = rnd_vec(), s2 = rnd_vec(), a2 = rnd_vec();
        @(negedge clk);
        op_u = u1; op_s = s1; acc_in = a1; idx = 2'd1; in_valid = 1'b1;
        @(negedge clk);
        check_bit("R6 b2b first valid", out_valid, 1'b1);
        check_vec("R6 b2b first data", acc_out, model(u1, s1, a1, 2'd1));
        op_u = u2; op_s = s2; acc_in = a2; idx = 2'd3;
        @(negedge clk);
        in_valid = 1'b0;
        check_bit("R6 b2b second valid", out_valid, 1'b1);
        check_vec("R6 b2b second data", acc_out, model(u2, s2, a2, 2'd3));
    endtask

    task automatic t_reset_midstream();
        @(negedge clk);
        op_u = rnd_vec(); in_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        check_bit("R7 reset beats valid", out_valid, 1'b0);
        check_vec("R7 reset clears data", acc_out, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_random_all_idx();
        t_extremes();
        t_unselected_ignored();
        t_zero_u();
        t_hold();
        t_back_to_back();
        t_reset_midstream();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule